// File: doc/BRIEF.md
# Snooping MSI Coherence Controller for a Direct-Mapped Cache

This block keeps the coherence state of every line of one write-back, direct-mapped cache that sits on a shared broadcast bus. It accepts read and write requests from its own processor, and it watches the transactions that other caches place on the bus. Each line is Invalid, Shared or Modified. The controller places fills, ownership requests and upgrades on the bus. It writes back a dirty victim before it replaces it. It drives a flush pulse whenever a snooped transaction needs data that this cache alone holds dirty.

The processor side accepts one request while `cpu_ready` is high and answers with a one-cycle `cpu_done`. A bus request is held until the bus grants it. In any cycle where a snoop and local activity touch the same line, the snoop is applied first. Only the tags and the states are kept here. The data array and arbitration between caches are outside the block.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is high, and neither `bus_req_valid` nor `snoop_flush` is asserted.
- R2: A read that misses raises a bus request with command 0 (read) for the line address. After the grant, `cpu_done` pulses one cycle later and the line is Shared.
- R3: A write that misses raises a bus request with command 1 (read-exclusive). After the grant, `cpu_done` pulses one cycle later and the line is Modified.
- R4: A write to a Shared line raises a bus request with command 2 (upgrade/invalidate). The line becomes Modified after the grant.
- R5: A read that hits a Shared or Modified line, and a write that hits a Modified line, pulse `cpu_done` in the cycle after acceptance and place nothing on the bus.
- R6: A snooped read (command 0) that hits a Modified line pulses `snoop_flush` one cycle later with the line address on `snoop_flush_addr`, and the line becomes Shared.
- R7: A snooped read-exclusive or upgrade (command 1 or 2) that hits a valid line makes it Invalid. A Modified line also flushes.
- R8: A snoop whose tag misses, a snoop that hits an Invalid line, and any snooped writeback (command 3) leave the state unchanged and do not flush.
- R9: A miss whose index holds a Modified line with another tag first requests a writeback (command 3) of the victim address. The same request is then turned into the fill.
- R10: When a snoop and a newly accepted local request target the same line in the same cycle, the local request is decided on the state after the snoop.
- R11: If a snoop invalidates the line while an upgrade is pending, the pending request becomes read-exclusive, and a grant in that cycle is ignored.
- R12: If a snoop hits the victim while its writeback is pending, the snoop flush supplies the data, the writeback is dropped, and the request becomes the fill.
- R13: At most one bus request is outstanding. `bus_req_valid` stays high until granted, and `cpu_ready` is low while a request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request, taken when `cpu_ready` is high |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address (tag above index) |
| cpu_ready | output | 1 | Controller can accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req_valid | output | 1 | Bus request outstanding |
| bus_req_cmd | output | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 writeback |
| bus_req_addr | output | ADDR_W | Line address of the request |
| bus_grant | input | 1 | Bus accepts the outstanding request |
| snoop_valid | input | 1 | Transaction from another cache seen on the bus |
| snoop_cmd | input | 2 | Snooped command, same encoding as `bus_req_cmd` |
| snoop_addr | input | ADDR_W | Snooped line address |
| snoop_flush | output | 1 | Dirty data supplied for a snooped transaction |
| snoop_flush_addr | output | ADDR_W | Address of the flushed line |

## Verification
The hardest situations to reach are the races between a snoop and a request that is already in flight: an upgrade that loses its Shared copy, and a victim writeback whose line is claimed by another cache. They cannot occur while the bus grants promptly. The bench therefore switches off its automatic grant, leaves the request pending, and then drives the snoop, in the R11 case in the same cycle as a grant. Same-cycle collisions of a new request with a snoop are produced by driving both inputs at the same falling edge.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_M = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_RD  = 2'd0,
    BC_RDX = 2'd1,
    BC_UPG = 2'd2,
    BC_WB  = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_WB   = 2'd1,
    FS_FILL = 2'd2
  } fsm_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TAG_W = 4,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx_a,
  output line_st_e         rd_st_a,
  output logic [TAG_W-1:0] rd_tag_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output line_st_e         rd_st_b,
  output logic [TAG_W-1:0] rd_tag_b,
  input  logic             wl_en,
  input  logic [IDX_W-1:0] wl_idx,
  input  line_st_e         wl_st,
  input  logic [TAG_W-1:0] wl_tag,
  input  logic             ws_en,
  input  logic [IDX_W-1:0] ws_idx,
  input  line_st_e         ws_st
);
  line_st_e         st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  // Local install wins over a snoop update on the same index; the request
  // machine suppresses its own write whenever the snoop hit the same line.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= LS_I;
        tag_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (wl_en && wl_idx == IDX_W'(i)) begin
          st_q[i]  <= wl_st;
          tag_q[i] <= wl_tag;
        end else if (ws_en && ws_idx == IDX_W'(i)) begin
          st_q[i]  <= ws_st;
        end
      end
    end
  end

  assign rd_st_a  = st_q[rd_idx_a];
  assign rd_tag_a = tag_q[rd_idx_a];
  assign rd_st_b  = st_q[rd_idx_b];
  assign rd_tag_b = tag_q[rd_idx_b];

  // R1: the encoding 2'b11 never appears on a read port
  assert_legal_state_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_st_a != line_st_e'(2'b11)) && (rd_st_b != line_st_e'(2'b11)));
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_cmd,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic [IDX_W-1:0]  snp_idx,
  input  line_st_e          cur_st,
  input  logic [TAG_W-1:0]  cur_tag,
  output logic              upd_en,
  output line_st_e          upd_st,
  output logic              snoop_flush,
  output logic [ADDR_W-1:0] snoop_flush_addr
);
  logic     hit;
  logic     need_flush;
  bus_cmd_e cmd;

  assign cmd     = bus_cmd_e'(snoop_cmd);
  assign snp_idx = snoop_addr[IDX_W-1:0];
  assign hit     = snoop_valid && (cur_st != LS_I) &&
                   (cur_tag == snoop_addr[ADDR_W-1:IDX_W]) && (cmd != BC_WB);

  always_comb begin
    upd_en     = 1'b0;
    upd_st     = cur_st;
    need_flush = 1'b0;
    if (hit) begin
      unique case (cmd)
        BC_RD: begin
          if (cur_st == LS_M) begin
            upd_en     = 1'b1;
            upd_st     = LS_S;
            need_flush = 1'b1;
          end
        end
        BC_RDX, BC_UPG: begin
          upd_en     = 1'b1;
          upd_st     = LS_I;
          need_flush = (cur_st == LS_M);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snoop_flush      <= 1'b0;
      snoop_flush_addr <= '0;
    end else begin
      snoop_flush <= need_flush;
      if (need_flush) snoop_flush_addr <= snoop_addr;
    end
  end

  // R6: a flush only ever answers a snoop from the previous cycle
  assert_flush_follows_snoop_R6: assert property (@(posedge clk) disable iff (rst)
    snoop_flush |-> $past(snoop_valid));

  // R8: a snooped writeback never causes a flush
  assert_wb_snoop_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (snoop_valid && snoop_cmd == 2'd3) |=> !snoop_flush);
endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [IDX_W-1:0]  lk_idx,
  input  line_st_e          lk_st,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic              snp_upd_en,
  input  logic [IDX_W-1:0]  snp_idx,
  input  line_st_e          snp_upd_st,
  output logic              bus_req_valid,
  output bus_cmd_e          bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_grant,
  output logic              wl_en,
  output logic [IDX_W-1:0]  wl_idx,
  output line_st_e          wl_st,
  output logic [TAG_W-1:0]  wl_tag
);
  fsm_e              fsm_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              pend_write_q;

  logic [ADDR_W-1:0] tgt_addr;
  logic [TAG_W-1:0]  tgt_tag;
  logic              snp_same;
  line_st_e          eff_st;
  logic              tag_hit;
  bus_cmd_e          fill_cmd;
  logic              upg_kill;
  logic              wb_kill;

  assign tgt_addr = (fsm_q == FS_IDLE) ? cpu_req_addr : pend_addr_q;
  assign lk_idx   = tgt_addr[IDX_W-1:0];
  assign tgt_tag  = tgt_addr[ADDR_W-1:IDX_W];
  assign snp_same = snp_upd_en && (snp_idx == lk_idx);
  // Snoop first: the local decision sees the state the snoop leaves behind.
  assign eff_st   = snp_same ? snp_upd_st : lk_st;
  assign tag_hit  = (eff_st != LS_I) && (lk_tag == tgt_tag);
  assign fill_cmd = pend_write_q ? BC_RDX : BC_RD;
  assign upg_kill = (fsm_q == FS_FILL) && (bus_req_cmd == BC_UPG) && snp_same;
  assign wb_kill  = (fsm_q == FS_WB) && snp_same;
  assign cpu_ready = (fsm_q == FS_IDLE);

  always_comb begin
    wl_en  = 1'b0;
    wl_idx = lk_idx;
    wl_st  = LS_I;
    wl_tag = lk_tag;
    if (bus_grant && bus_req_valid) begin
      if (fsm_q == FS_WB && !wb_kill) begin
        wl_en = 1'b1;
        wl_st = LS_I;
      end else if (fsm_q == FS_FILL && !upg_kill) begin
        wl_en  = 1'b1;
        wl_st  = (bus_req_cmd == BC_RD) ? LS_S : LS_M;
        wl_tag = tgt_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q         <= FS_IDLE;
      pend_addr_q   <= '0;
      pend_write_q  <= 1'b0;
      bus_req_valid <= 1'b0;
      bus_req_cmd   <= BC_RD;
      bus_req_addr  <= '0;
      cpu_done      <= 1'b0;
    end else begin
      cpu_done <= 1'b0;
      unique case (fsm_q)
        FS_IDLE: begin
          if (cpu_req_valid) begin
            pend_addr_q  <= cpu_req_addr;
            pend_write_q <= cpu_req_write;
            if (tag_hit && (!cpu_req_write || eff_st == LS_M)) begin
              cpu_done <= 1'b1;
            end else if (tag_hit) begin
              fsm_q         <= FS_FILL;
              bus_req_valid <= 1'b1;
              bus_req_cmd   <= BC_UPG;
              bus_req_addr  <= cpu_req_addr;
            end else if (eff_st == LS_M) begin
              fsm_q         <= FS_WB;
              bus_req_valid <= 1'b1;
              bus_req_cmd   <= BC_WB;
              bus_req_addr  <= {lk_tag, lk_idx};
            end else begin
              fsm_q         <= FS_FILL;
              bus_req_valid <= 1'b1;
              bus_req_cmd   <= cpu_req_write ? BC_RDX : BC_RD;
              bus_req_addr  <= cpu_req_addr;
            end
          end
        end
        FS_WB: begin
          if (wb_kill || bus_grant) begin
            fsm_q        <= FS_FILL;
            bus_req_cmd  <= fill_cmd;
            bus_req_addr <= pend_addr_q;
          end
        end
        FS_FILL: begin
          if (upg_kill) begin
            bus_req_cmd <= BC_RDX;
          end else if (bus_grant) begin
            fsm_q         <= FS_IDLE;
            bus_req_valid <= 1'b0;
            cpu_done      <= 1'b1;
          end
        end
        default: fsm_q <= FS_IDLE;
      endcase
    end
  end

  // R13: a request stays raised until it is granted
  assert_req_held_R13: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && !bus_grant) |=> bus_req_valid);

  // R13: the processor side is closed while the bus is in use
  assert_busy_means_req_R13: assert property (@(posedge clk) disable iff (rst)
    !cpu_ready |-> bus_req_valid);

  // R2: a granted fill completes in the next cycle
  assert_fill_completes_R2: assert property (@(posedge clk) disable iff (rst)
    (fsm_q == FS_FILL && bus_grant && !upg_kill) |=> (cpu_done && !bus_req_valid));

  // R11: a lost upgrade is re-issued as read-exclusive
  assert_upg_becomes_rdx_R11: assert property (@(posedge clk) disable iff (rst)
    upg_kill |=> (bus_req_valid && bus_req_cmd == BC_RDX));

  // R5: completion follows an accepted request or a grant
  assert_done_has_cause_R5: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> ($past(cpu_req_valid) || $past(bus_grant)));
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 16,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_grant,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_cmd,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_flush,
  output logic [ADDR_W-1:0] snoop_flush_addr
);
  logic [IDX_W-1:0] lk_idx, snp_idx, wl_idx;
  line_st_e         lk_st, snp_cur_st, snp_upd_st, wl_st;
  logic [TAG_W-1:0] lk_tag, snp_cur_tag, wl_tag;
  logic             snp_upd_en, wl_en;
  bus_cmd_e         req_cmd;

  msi_line_store #(.LINES(LINES), .TAG_W(TAG_W)) store_i (
    .clk      (clk),
    .rst      (rst),
    .rd_idx_a (lk_idx),
    .rd_st_a  (lk_st),
    .rd_tag_a (lk_tag),
    .rd_idx_b (snp_idx),
    .rd_st_b  (snp_cur_st),
    .rd_tag_b (snp_cur_tag),
    .wl_en    (wl_en),
    .wl_idx   (wl_idx),
    .wl_st    (wl_st),
    .wl_tag   (wl_tag),
    .ws_en    (snp_upd_en),
    .ws_idx   (snp_idx),
    .ws_st    (snp_upd_st)
  );

  msi_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) snoop_i (
    .clk              (clk),
    .rst              (rst),
    .snoop_valid      (snoop_valid),
    .snoop_cmd        (snoop_cmd),
    .snoop_addr       (snoop_addr),
    .snp_idx          (snp_idx),
    .cur_st           (snp_cur_st),
    .cur_tag          (snp_cur_tag),
    .upd_en           (snp_upd_en),
    .upd_st           (snp_upd_st),
    .snoop_flush      (snoop_flush),
    .snoop_flush_addr (snoop_flush_addr)
  );

  msi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) fsm_i (
    .clk           (clk),
    .rst           (rst),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_write (cpu_req_write),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_ready     (cpu_ready),
    .cpu_done      (cpu_done),
    .lk_idx        (lk_idx),
    .lk_st         (lk_st),
    .lk_tag        (lk_tag),
    .snp_upd_en    (snp_upd_en),
    .snp_idx       (snp_idx),
    .snp_upd_st    (snp_upd_st),
    .bus_req_valid (bus_req_valid),
    .bus_req_cmd   (req_cmd),
    .bus_req_addr  (bus_req_addr),
    .bus_grant     (bus_grant),
    .wl_en         (wl_en),
    .wl_idx        (wl_idx),
    .wl_st         (wl_st),
    .wl_tag        (wl_tag)
  );

  assign bus_req_cmd = req_cmd;

  // R7: an invalidating snoop on a dirty line is answered with a flush
  assert_inval_dirty_flushes_R7: assert property (@(posedge clk) disable iff (rst)
    (snoop_valid && (snoop_cmd == 2'd1 || snoop_cmd == 2'd2) && snp_cur_st == LS_M &&
     snp_cur_tag == snoop_addr[ADDR_W-1:IDX_W]) |=> (snoop_flush && snoop_flush_addr == $past(snoop_addr)));
endmodule

// File: tb/msi_line_ctrl_tb_top.sv
module msi_line_ctrl_tb_top;
  localparam int ADDR_W = 8;
  localparam int K_BUS = 0, K_FLUSH = 1, K_DONE = 2;

  typedef struct {
    int           kind;
    logic [1:0]   cmd;
    logic [7:0]   addr;
    string        req;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cpu_req_valid = 1'b0;
  logic              cpu_req_write = 1'b0;
  logic [ADDR_W-1:0] cpu_req_addr = '0;
  logic              cpu_ready, cpu_done;
  logic              bus_req_valid;
  logic [1:0]        bus_req_cmd;
  logic [ADDR_W-1:0] bus_req_addr;
  logic              bus_grant = 1'b0;
  logic              snoop_valid = 1'b0;
  logic [1:0]        snoop_cmd = '0;
  logic [ADDR_W-1:0] snoop_addr = '0;
  logic              snoop_flush;
  logic [ADDR_W-1:0] snoop_flush_addr;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 0;
  bit   auto_gnt = 1;
  bit   man_gnt  = 0;

  always #10 clk = ~clk;

  msi_line_ctrl #(.ADDR_W(ADDR_W), .LINES(16)) dut_i (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic void push(input int kind, input logic [1:0] cmd,
                               input logic [7:0] addr, input string req);
    exp_t e;
    e.kind = kind; e.cmd = cmd; e.addr = addr; e.req = req;
    exp_q.push_back(e);
  endfunction

  task automatic observe(input int kind, input logic [1:0] cmd, input logic [7:0] addr);
    exp_t e;
    if (exp_q.size() == 0) begin
      check(0, "any", "unexpected event kind", kind, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == kind, e.req, "event kind", kind, e.kind);
      if (e.kind == kind && kind != K_DONE) begin
        check(e.addr == addr, e.req, "event address", addr, e.addr);
        if (kind == K_BUS) check(e.cmd == cmd, e.req, "bus command", cmd, e.cmd);
      end
    end
  endtask

  // monitor: flush, then new bus request, then completion, sampled at negedge
  initial begin
    logic       pv = 0;
    logic [1:0] pc = 0;
    logic [7:0] pa = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (snoop_flush) observe(K_FLUSH, 2'd0, snoop_flush_addr);
        if (bus_req_valid && (!pv || bus_req_cmd != pc || bus_req_addr != pa))
          observe(K_BUS, bus_req_cmd, bus_req_addr);
        if (cpu_done) observe(K_DONE, 2'd0, 8'd0);
        pv = bus_req_valid; pc = bus_req_cmd; pa = bus_req_addr;
      end
    end
  end

  // grant responder
  initial begin
    int gcnt = 0;
    forever begin
      @(negedge clk);
      if (bus_grant) begin
        bus_grant = 1'b0;
      end else if (man_gnt) begin
        bus_grant = 1'b1;
        man_gnt = 0;
      end else if (auto_gnt && bus_req_valid && !rst) begin
        if (gcnt == 1) begin bus_grant = 1'b1; gcnt = 0; end
        else gcnt++;
      end else begin
        gcnt = 0;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", "run timed out", 0, 1);
    finish_run();
  end

  task automatic cpu_issue(input bit wr, input logic [7:0] a);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a;
    @(negedge clk);
    cpu_req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!cpu_done) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic cpu_op(input bit wr, input logic [7:0] a);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a;
    do begin
      @(negedge clk);
      cpu_req_valid = 1'b0;
    end while (!cpu_done);
    repeat (2) @(negedge clk);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [7:0] a);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_cmd = c; snoop_addr = a;
    @(negedge clk);
    snoop_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic both_same_cycle(input bit wr, input logic [7:0] a, input logic [1:0] c);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a;
    snoop_valid = 1'b1; snoop_cmd = c; snoop_addr = a;
    @(negedge clk);
    cpu_req_valid = 1'b0; snoop_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cpu_ready == 1'b1, "R1", "cpu_ready after reset", cpu_ready, 1);
    check(bus_req_valid == 1'b0, "R1", "bus_req_valid after reset", bus_req_valid, 0);
    check(snoop_flush == 1'b0, "R1", "snoop_flush after reset", snoop_flush, 0);

    // R2 read miss; R5 hits
    push(K_BUS, 2'd0, 8'h12, "R2"); push(K_DONE, 0, 0, "R2");
    cpu_op(0, 8'h12);
    push(K_DONE, 0, 0, "R5"); cpu_op(0, 8'h12);
    // R4 write to Shared
    push(K_BUS, 2'd2, 8'h12, "R4"); push(K_DONE, 0, 0, "R4");
    cpu_op(1, 8'h12);
    push(K_DONE, 0, 0, "R5"); cpu_op(1, 8'h12);
    push(K_DONE, 0, 0, "R5"); cpu_op(0, 8'h12);
    // R3 write miss
    push(K_BUS, 2'd1, 8'h25, "R3"); push(K_DONE, 0, 0, "R3");
    cpu_op(1, 8'h25);
    // R6 snooped read on Modified, line then Shared
    push(K_FLUSH, 0, 8'h25, "R6"); snoop(2'd0, 8'h25);
    push(K_BUS, 2'd2, 8'h25, "R6"); push(K_DONE, 0, 0, "R6");
    cpu_op(1, 8'h25);
    // R7 invalidating snoops
    push(K_FLUSH, 0, 8'h12, "R7"); snoop(2'd1, 8'h12);
    push(K_BUS, 2'd0, 8'h12, "R7"); push(K_DONE, 0, 0, "R7");
    cpu_op(0, 8'h12);
    snoop(2'd2, 8'h12);
    push(K_BUS, 2'd0, 8'h12, "R7"); push(K_DONE, 0, 0, "R7");
    cpu_op(0, 8'h12);
    // R8 ignored snoops: tag miss, writeback, Invalid line
    snoop(2'd1, 8'h32);
    snoop(2'd3, 8'h25);
    snoop(2'd0, 8'h09);
    push(K_DONE, 0, 0, "R8"); cpu_op(1, 8'h25);
    push(K_DONE, 0, 0, "R8"); cpu_op(0, 8'h12);
    // R9 dirty victim
    push(K_BUS, 2'd3, 8'h25, "R9"); push(K_BUS, 2'd0, 8'h45, "R9");
    push(K_DONE, 0, 0, "R9");
    cpu_op(0, 8'h45);
    // R10 snoop invalidates Shared line in same cycle as a read
    push(K_BUS, 2'd0, 8'h45, "R10"); push(K_DONE, 0, 0, "R10");
    both_same_cycle(0, 8'h45, 2'd1);
    wait_done();
    push(K_BUS, 2'd1, 8'h17, "R3"); push(K_DONE, 0, 0, "R3");
    cpu_op(1, 8'h17);
    // R10 snooped read on Modified in same cycle as a write
    push(K_FLUSH, 0, 8'h17, "R10"); push(K_BUS, 2'd2, 8'h17, "R10");
    push(K_DONE, 0, 0, "R10");
    both_same_cycle(1, 8'h17, 2'd0);
    wait_done();
    // R11 upgrade loses its copy while pending
    push(K_FLUSH, 0, 8'h17, "R6"); snoop(2'd0, 8'h17);
    auto_gnt = 0;
    push(K_BUS, 2'd2, 8'h17, "R11");
    cpu_issue(1, 8'h17);
    repeat (4) @(negedge clk);
    check(bus_req_valid == 1'b1, "R13", "request held without grant", bus_req_valid, 1);
    check(cpu_ready == 1'b0, "R13", "cpu_ready while pending", cpu_ready, 0);
    push(K_BUS, 2'd1, 8'h17, "R11");
    @(posedge clk); man_gnt = 1;
    @(negedge clk);
    snoop_valid = 1'b1; snoop_cmd = 2'd1; snoop_addr = 8'h17;
    @(negedge clk);
    snoop_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(bus_req_valid == 1'b1, "R11", "request after ignored grant", bus_req_valid, 1);
    push(K_DONE, 0, 0, "R11");
    @(posedge clk); man_gnt = 1;
    wait_done();
    // R12 victim claimed while writeback pending
    push(K_BUS, 2'd3, 8'h17, "R12");
    cpu_issue(0, 8'h27);
    repeat (3) @(negedge clk);
    push(K_FLUSH, 0, 8'h17, "R12"); push(K_BUS, 2'd0, 8'h27, "R12");
    snoop(2'd0, 8'h17);
    push(K_DONE, 0, 0, "R12");
    @(posedge clk); man_gnt = 1;
    wait_done();
    auto_gnt = 1;
    push(K_DONE, 0, 0, "R12"); cpu_op(0, 8'h27);
    push(K_BUS, 2'd0, 8'h17, "R12"); push(K_DONE, 0, 0, "R12");
    cpu_op(0, 8'h17);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R13", "missing expected events", exp_q.size(), 0);
    finish_run();
  end
endmodule